// File: doc/BRIEF.md
# Port-Group Egress Mask Resolver

This block works out which ports an L2 frame leaves on. It holds one table of port-group entries. Each entry is a bitmask with one bit for every physical port and one more bit, at position NUM_PORTS, for the CPU port module. For each lookup request it reads three entries and ANDs them together. The first is a destination group: on a MAC-table hit it is named by the hit's index, and on a miss it comes from a flood selector picked by frame class. The second is an aggregation group, at 64 plus the 4-bit link-aggregation code, which leaves one member port per flow. The third is a source group, at 80 plus the ingress port, which says where that port may forward.

A single configuration write port loads table entries and the three flood selectors. Requests are accepted every cycle. The mask comes out with a valid flag two cycles after its request.

Top module: `pgr_mask_resolver`

## Requirements
- R1: A request sampled with `req_valid` high in cycle k gives `out_valid` high in cycle k+2. `out_mask` in that cycle equals destination entry AND aggregation entry AND source entry. A new request may be given every cycle.
- R2: With `req_hit` high, the destination entry is read at index `req_dst_idx` (0 to 63).
- R3: With `req_hit` low, the destination index is taken from a flood selector chosen by `req_class`. The codes are 2'b00 unknown unicast, 2'b01 multicast, and 2'b10 or 2'b11 broadcast. The aggregation entry is read at 64 + `req_lag`, and the source entry at 80 + `req_src_port`.
- R4: The link-aggregation code picks the entry. Writing entry 64 + c changes only results for requests that carry code c.
- R5: When `req_src_port` is at or above NUM_PORTS, the resulting `out_mask` is all zero, while `out_valid` still follows R1.
- R6: Table contents after reset:
  - entry i below NUM_PORTS holds only bit i;
  - entries NUM_PORTS to 58 are zero;
  - entry 59 holds only the CPU bit;
  - entry 60 holds all physical-port bits and no CPU bit;
  - entries 61 to 79 are all ones;
  - entry 80+i is all ones except bit i.
- R7: After reset, the unicast selector is 60, and the multicast and broadcast selectors are both 61. Unknown unicast therefore never carries the CPU bit until entry 60 is rewritten to include it.
- R8: A table write (`cfg_sel_reg` low) to index DEPTH or above changes nothing. A selector write (`cfg_sel_reg` high) loads `cfg_wdata[5:0]` into selector `cfg_idx`, where 0 is unicast, 1 is multicast and 2 is broadcast. A selector write with `cfg_idx` above 2 changes nothing.
- R9: The table is read in the cycle after a request is sampled. A write in the same cycle as the request is seen by that request's result. A write in the following cycle is not seen by it, and is seen only by later requests.
- R10: After reset, and in every cycle where `out_valid` is low, `out_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request strobe |
| req_hit | input | 1 | MAC-table hit for this frame |
| req_dst_idx | input | 6 | Destination group index on a hit |
| req_class | input | 2 | Frame class used on a miss |
| req_lag | input | 4 | Link-aggregation code |
| req_src_port | input | 4 | Ingress port number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_reg | input | 1 | 1 writes a flood selector, 0 writes a table entry |
| cfg_idx | input | 7 | Entry or selector index |
| cfg_wdata | input | NUM_PORTS+1 | Write data (selectors take the low 6 bits) |
| out_valid | output | 1 | Result valid |
| out_mask | output | NUM_PORTS+1 | Egress port mask, CPU bit on top |

## Verification
A corrupted table entry or selector shows up only in results that read it. It appears on `out_mask` exactly two cycles after the first request that touches it, and never appears through any other request. For that reason the bench replays every request against a behavioural table and compares `out_valid` and `out_mask` on every cycle. This catches a stale or misaddressed entry on the first lookup that reads it. A slip in pipeline timing, or in the ordering of a read against a write to the same entry, breaks the R9 results at once, because there the old and new contents differ. An out-of-range write that aliases onto a real entry shows up on the next lookup of that entry.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int TIDX_W       = 7;
  localparam int DIDX_W       = 6;
  localparam int LAG_W        = 4;
  localparam int PORT_W       = 4;
  localparam int NSEL         = 3;
  localparam int AGGR_BASE    = 64;
  localparam int SRC_BASE     = 80;
  localparam int IDX_CPU      = 59;
  localparam int IDX_UC_FLOOD = 60;
  localparam int IDX_MC_FLOOD = 61;

  typedef enum logic [1:0] {
    CLS_UCAST  = 2'b00,
    CLS_MCAST  = 2'b01,
    CLS_BCAST  = 2'b10,
    CLS_BCAST2 = 2'b11
  } frame_cls_e;
endpackage

// File: rtl/pgr_rst_sync.sv
module pgr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pgr_flood_sel.sv
module pgr_flood_sel
  import pgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TIDX_W-1:0] wr_idx,
  input  logic [DIDX_W-1:0] wr_data,
  input  logic              hit,
  input  logic [DIDX_W-1:0] hit_idx,
  input  logic [1:0]        cls,
  output logic [DIDX_W-1:0] dst_idx,
  output logic [DIDX_W-1:0] sel_uc,
  output logic [DIDX_W-1:0] sel_mc,
  output logic [DIDX_W-1:0] sel_bc
);
  logic [NSEL-1:0][DIDX_W-1:0] sel_q;

  function automatic logic [DIDX_W-1:0] sel_rst(int s);
    if (s == 0) return DIDX_W'(IDX_UC_FLOOD);
    return DIDX_W'(IDX_MC_FLOOD);
  endfunction

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    localparam logic [DIDX_W-1:0] RST = sel_rst(s);
    logic en;
    assign en = wr_en && (wr_idx == TIDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel_q[s] <= RST;
      else if (en) sel_q[s] <= wr_data;
    end
  end

  assign sel_uc = sel_q[0];
  assign sel_mc = sel_q[1];
  assign sel_bc = sel_q[2];

  always_comb begin
    if (hit) begin
      dst_idx = hit_idx;
    end else begin
      case (frame_cls_e'(cls))
        CLS_UCAST: dst_idx = sel_uc;
        CLS_MCAST: dst_idx = sel_mc;
        default:   dst_idx = sel_bc;
      endcase
    end
  end
endmodule

// File: rtl/pgr_table.sv
module pgr_table
  import pgr_pkg::*;
#(
  parameter int NUM_PORTS = 11,
  parameter int NRD       = 3,
  localparam int MASK_W   = NUM_PORTS + 1,
  localparam int DEPTH    = SRC_BASE + NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [TIDX_W-1:0]           wr_idx,
  input  logic [MASK_W-1:0]           wr_data,
  input  logic [NRD-1:0][TIDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][MASK_W-1:0]  rd_data
);
  logic [MASK_W-1:0] ent [DEPTH];

  function automatic logic [MASK_W-1:0] ent_rst(int i);
    logic [MASK_W-1:0] all_ones;
    all_ones = '1;
    if (i < NUM_PORTS)                      return MASK_W'(1) << i;
    if (i == IDX_CPU)                       return MASK_W'(1) << NUM_PORTS;
    if (i == IDX_UC_FLOOD)                  return all_ones >> 1;
    if (i > IDX_UC_FLOOD && i < SRC_BASE)   return all_ones;
    if (i >= SRC_BASE)                      return all_ones & ~(MASK_W'(1) << (i - SRC_BASE));
    return '0;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [MASK_W-1:0] RST = ent_rst(g);
    logic              en;
    logic [MASK_W-1:0] q;
    assign en = wr_en && (wr_idx == TIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (en) q <= wr_data;
    end
    assign ent[g] = q;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = (rd_idx[r] < TIDX_W'(DEPTH)) ? ent[rd_idx[r]] : '0;
  end
endmodule

// File: rtl/pgr_mask_resolver.sv
module pgr_mask_resolver
  import pgr_pkg::*;
#(
  parameter int NUM_PORTS = 11,
  localparam int MASK_W   = NUM_PORTS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic [5:0]        req_dst_idx,
  input  logic [1:0]        req_class,
  input  logic [3:0]        req_lag,
  input  logic [3:0]        req_src_port,
  input  logic              cfg_we,
  input  logic              cfg_sel_reg,
  input  logic [6:0]        cfg_idx,
  input  logic [MASK_W-1:0] cfg_wdata,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask
);
  logic rst_sync_n;

  pgr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Flood selectors and destination index choice
  logic [DIDX_W-1:0] dst_idx_c;
  logic [DIDX_W-1:0] sel_uc, sel_mc, sel_bc;

  pgr_flood_sel u_flood (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we && cfg_sel_reg),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata[DIDX_W-1:0]),
    .hit     (req_hit),
    .hit_idx (req_dst_idx),
    .cls     (req_class),
    .dst_idx (dst_idx_c),
    .sel_uc  (sel_uc),
    .sel_mc  (sel_mc),
    .sel_bc  (sel_bc)
  );

  // Stage 1: captured request
  logic              s1_valid_q, s1_valid_d;
  logic [DIDX_W-1:0] s1_didx_q,  s1_didx_d;
  logic [LAG_W-1:0]  s1_lag_q,   s1_lag_d;
  logic [PORT_W-1:0] s1_port_q,  s1_port_d;
  logic              s1_en;

  always_comb begin
    s1_valid_d = req_valid;
    s1_en      = req_valid;
    s1_didx_d  = dst_idx_c;
    s1_lag_d   = req_lag;
    s1_port_d  = req_src_port;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s1_didx_q  <= '0;
      s1_lag_q   <= '0;
      s1_port_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_en) begin
        s1_didx_q <= s1_didx_d;
        s1_lag_q  <= s1_lag_d;
        s1_port_q <= s1_port_d;
      end
    end
  end

  // Table with three read ports: destination, aggregation, source
  logic [2:0][TIDX_W-1:0] rd_idx;
  logic [2:0][MASK_W-1:0] rd_data;

  always_comb begin
    rd_idx[0] = TIDX_W'(s1_didx_q);
    rd_idx[1] = TIDX_W'(AGGR_BASE) + TIDX_W'(s1_lag_q);
    rd_idx[2] = TIDX_W'(SRC_BASE)  + TIDX_W'(s1_port_q);
  end

  pgr_table #(.NUM_PORTS(NUM_PORTS), .NRD(3)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we && !cfg_sel_reg),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // Stage 2: combine and register the result
  logic              port_ok;
  logic              out_valid_d;
  logic [MASK_W-1:0] out_mask_d;

  always_comb begin
    port_ok     = (s1_port_q < PORT_W'(NUM_PORTS));
    out_valid_d = s1_valid_q;
    out_mask_d  = '0;
    if (s1_valid_q && port_ok) out_mask_d = rd_data[0] & rd_data[1] & rd_data[2];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_mask  <= out_mask_d;
    end
  end
endmodule

// File: rtl/pgr_mask_resolver_chk.sv
module pgr_mask_resolver_chk
  import pgr_pkg::*;
#(
  parameter int NUM_PORTS = 11,
  localparam int MASK_W   = NUM_PORTS + 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_hit,
  input logic [5:0]        req_dst_idx,
  input logic [3:0]        req_src_port,
  input logic              cfg_we,
  input logic              cfg_sel_reg,
  input logic [5:0]        s1_didx_q,
  input logic [5:0]        sel_uc,
  input logic [5:0]        sel_mc,
  input logic [5:0]        sel_bc,
  input logic              out_valid,
  input logic [MASK_W-1:0] out_mask
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)         age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd3) |-> (out_valid == $past(req_valid, 2))); // R1

  AST_HIT_INDEX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 2'd2 && $past(req_valid && req_hit)) |-> (s1_didx_q == $past(req_dst_idx))); // R2

  AST_BAD_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd3 && $past(req_valid, 2) && ($past(req_src_port, 2) >= 4'(NUM_PORTS)))
      |-> (out_mask == '0)); // R5

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 2'd1 && !$past(cfg_we && cfg_sel_reg))
      |-> ($stable(sel_uc) && $stable(sel_mc) && $stable(sel_bc))); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> (out_mask == '0)); // R10
endmodule

bind pgr_mask_resolver pgr_mask_resolver_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .req_valid    (req_valid),
  .req_hit      (req_hit),
  .req_dst_idx  (req_dst_idx),
  .req_src_port (req_src_port),
  .cfg_we       (cfg_we),
  .cfg_sel_reg  (cfg_sel_reg),
  .s1_didx_q    (s1_didx_q),
  .sel_uc       (sel_uc),
  .sel_mc       (sel_mc),
  .sel_bc       (sel_bc),
  .out_valid    (out_valid),
  .out_mask     (out_mask)
);

// File: tb/pgr_mask_resolver_tb_top.sv
module pgr_mask_resolver_tb_top;
  localparam int NP = 11;
  localparam int MW = NP + 1;
  localparam int DP = 80 + NP;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_hit;
  logic [5:0]    req_dst_idx;
  logic [1:0]    req_class;
  logic [3:0]    req_lag, req_src_port;
  logic          cfg_we, cfg_sel_reg;
  logic [6:0]    cfg_idx;
  logic [MW-1:0] cfg_wdata;
  logic          out_valid;
  logic [MW-1:0] out_mask;

  int n_checks = 0;
  int n_errors = 0;
  bit chk_on   = 0;
  bit done     = 0;

  pgr_mask_resolver #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_dst_idx(req_dst_idx), .req_class(req_class), .req_lag(req_lag),
    .req_src_port(req_src_port), .cfg_we(cfg_we), .cfg_sel_reg(cfg_sel_reg),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_mask(out_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  logic [MW-1:0] m_tbl [DP];
  int            m_sel [3];
  bit            p_valid;
  int            p_d, p_lag, p_port;
  bit            e_valid;
  logic [MW-1:0] e_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DP; i++) begin
        if (i < NP)                 m_tbl[i] = MW'(1) << i;
        else if (i == 59)           m_tbl[i] = MW'(1) << NP;
        else if (i == 60)           m_tbl[i] = (MW'(1) << NP) - 1;
        else if (i > 60 && i < 80)  m_tbl[i] = '1;
        else if (i >= 80)           m_tbl[i] = ~(MW'(1) << (i - 80));
        else                        m_tbl[i] = '0;
      end
      m_sel[0] = 60; m_sel[1] = 61; m_sel[2] = 61;
      p_valid = 0; p_d = 0; p_lag = 0; p_port = 0;
      e_valid = 0; e_mask = '0;
    end else begin
      e_valid = p_valid;
      e_mask  = '0;
      if (p_valid && p_port < NP)
        e_mask = m_tbl[p_d] & m_tbl[64 + p_lag] & m_tbl[80 + p_port];
      p_valid = req_valid;
      if (req_valid) begin
        if (req_hit)             p_d = int'(req_dst_idx);
        else if (req_class == 0) p_d = m_sel[0];
        else if (req_class == 1) p_d = m_sel[1];
        else                     p_d = m_sel[2];
        p_lag  = int'(req_lag);
        p_port = int'(req_src_port);
      end
      if (cfg_we) begin
        if (cfg_sel_reg) begin
          if (cfg_idx < 3) m_sel[cfg_idx] = int'(cfg_wdata[5:0]);
        end else if (int'(cfg_idx) < DP) begin
          m_tbl[cfg_idx] = cfg_wdata;
        end
      end
    end
  end

  task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 valid", MW'(out_valid), MW'(e_valid));
      chk("R1 mask", out_mask, e_mask);
    end
  end

  task automatic look(bit hit, int dst, int cls, int lag, int port,
                      logic [MW-1:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_hit = hit; req_dst_idx = 6'(dst); req_class = 2'(cls);
    req_lag = 4'(lag); req_src_port = 4'(port);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(tag, MW'(out_valid), MW'(1));
    chk(tag, out_mask, exp);
  endtask

  task automatic wr(bit sel, int idx, logic [MW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel_reg = sel; cfg_idx = 7'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_hit = 0; req_dst_idx = '0; req_class = '0;
    req_lag = '0; req_src_port = '0; cfg_we = 0; cfg_sel_reg = 0; cfg_idx = '0;
    cfg_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R10 reset valid", MW'(out_valid), '0);
    chk("R10 reset mask", out_mask, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R6 / R7: reset contents and selectors
    look(0, 0, 0, 0, 0, 12'h7FE, "R7 uc flood excludes CPU");
    chk("R7 CPU bit clear", MW'(out_mask[NP]), '0);
    look(1, 3, 0, 0, 0, 12'h008, "R6 unicast group");
    look(1, 59, 0, 0, 2, 12'h800, "R6 CPU whitelist");
    look(1, 20, 0, 0, 1, 12'h000, "R6 empty multicast group");
    look(0, 0, 2, 0, 0, 12'hFFE, "R7 bcast selector 61");

    // R5: bad ingress port
    look(1, 61, 0, 0, 11, 12'h000, "R5 port == NUM_PORTS");
    look(1, 61, 0, 0, 15, 12'h000, "R5 port 15");
    look(1, 61, 0, 0, 10, 12'hBFF, "R5 last good port");

    // R4: aggregation lookup
    wr(0, 69, 12'h004);
    look(0, 0, 2, 5, 1, 12'h004, "R4 lag 5 picks port 2");
    look(0, 0, 2, 0, 1, 12'hFFD, "R4 lag 0 unaffected");
    look(0, 0, 2, 15, 1, 12'hFFD, "R4 lag 15 unaffected");

    // R3: class selection
    wr(1, 1, 12'd62);
    wr(0, 62, 12'h0F0);
    look(0, 0, 1, 0, 0, 12'h0F0, "R3 mcast uses selector");
    look(0, 0, 2, 0, 0, 12'hFFE, "R3 bcast class 10");
    look(0, 0, 3, 0, 0, 12'hFFE, "R3 bcast class 11");
    look(0, 0, 0, 0, 0, 12'h7FE, "R3 ucast class 00");
    look(1, 62, 0, 0, 0, 12'h0F0, "R2 hit ignores class");

    // R7: enabling unknown unicast towards the CPU
    wr(0, 60, 12'hFFF);
    look(0, 0, 0, 0, 0, 12'hFFE, "R7 uc flood now includes CPU");

    // R8: ignored writes
    wr(0, 91, 12'h000);
    wr(0, 127, 12'h000);
    wr(1, 3, 12'h005);
    wr(1, 9, 12'h001);
    look(1, 1, 0, 0, 10, 12'h002, "R8 entry 90 kept");
    look(1, 27, 0, 0, 0, 12'h000, "R8 entry 27 kept");
    look(0, 0, 0, 0, 0, 12'hFFE, "R8 uc selector kept");
    look(1, 3, 0, 0, 0, 12'h008, "R8 entry 3 kept");
    look(0, 0, 3, 0, 0, 12'hFFE, "R8 bc selector kept");

    // R9: write against read ordering
    @(negedge clk);
    req_valid = 1; req_hit = 1; req_dst_idx = 6'd5; req_src_port = 4'd0; req_lag = 4'd0;
    @(negedge clk);
    req_valid = 0;
    cfg_we = 1; cfg_sel_reg = 0; cfg_idx = 7'd5; cfg_wdata = 12'h0A0;
    @(negedge clk);
    cfg_we = 0;
    chk("R9 write after request not seen", out_mask, 12'h020);
    look(1, 5, 0, 0, 0, 12'h0A0, "R9 later request sees write");
    @(negedge clk);
    req_valid = 1; req_hit = 1; req_dst_idx = 6'd5;
    cfg_we = 1; cfg_sel_reg = 0; cfg_idx = 7'd5; cfg_wdata = 12'h300;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    @(negedge clk);
    chk("R9 same-cycle write seen", out_mask, 12'h300);

    // R10: idle output
    @(negedge clk);
    chk("R10 idle valid", MW'(out_valid), '0);
    chk("R10 idle mask", out_mask, '0);

    // R1: back-to-back stream with interleaved writes, checked by the model
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      req_valid    = (k % 7) != 3;
      req_hit      = (k % 3) == 0;
      req_dst_idx  = 6'((k * 13) % 64);
      req_class    = 2'(k % 4);
      req_lag      = 4'((k * 5) % 16);
      req_src_port = 4'((k * 3) % 13);
      cfg_we       = (k % 5) == 2;
      cfg_sel_reg  = (k % 10) == 7;
      cfg_idx      = cfg_sel_reg ? 7'(k % 4) : 7'((k * 11) % 96);
      cfg_wdata    = MW'(k * 373 + 45);
    end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    repeat (4) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule